// File: doc/BRIEF.md
# Configurable Parallel External Bus Master

This block turns single 16-bit read or write requests from on-chip logic into timed cycles on an external parallel bus. A caller presents a request together with a direction, an address and write data. The block then runs an address phase and a data phase, with programmable wait cycles in each, and a one-cycle hold. It reports completion with a one-cycle done pulse, and read data is valid in that same cycle. On a 4-bit or 8-bit bus the 16-bit word moves in several narrow beats, lowest part first, and the address advances by one for each beat.

The external side has an address pin group and a data pin group. The data pins are split into output, output-enable and input, and the pad ring merges them. There are two chip selects, an address-latch strobe, and two strobe pins. Configuration inputs are expected to be static while a transfer runs. They choose the bus width and how many top address lines are given up to chip selects. Each of the two chip-select regions has its own strobe style, data wait count, and polarity for its chip select and strobes. Address/data multiplexing is switched on or off for all regions at once.

Top module: `extbus_master`

## Requirements
- R1: Reset forces the idle state at once, even in the middle of a transfer. In idle, busy_o and done_o are 0 and pd_oe_o is 0. Each cs_o bit equals its cs_pol_i bit. rd_o and wr_o equal the strobe polarity bit of the selected region, and ale_o equals ale_pol_i.
- R2: A request with req_i high while busy_o is 0 is accepted at that clock edge, and busy_o is 1 from the next cycle through the done cycle. A request presented while busy_o is 1 is ignored: no extra transfer, no change of address or data.
- R3: Each beat takes 1+addr_wait_i address cycles, then 1+data-wait data cycles for the selected region, then 1 hold cycle. After the last beat, done_o is high for exactly one cycle, with busy_o still high.
- R4: width_i encodes the bus width: 0 is 4 bits (4 beats), 1 is 8 bits (2 beats), and 2 or 3 is 16 bits (1 beat). Beats carry the word lowest part first, at addresses base, base+1, and so on.
- R5: In a read, the data pins are sampled on the last data cycle of each beat and assembled into rdata_o, which is valid while done_o is high. pd_oe_o is 0 in the data and hold phases of a read.
- R6: In a write, pd_oe_o is 1 in the data and hold phases, and pd_o carries the beat's slice of the write word in its low bits.
- R7: strb_style_i bit n selects the strobe style of region n. With 0, rd_o pulses during data cycles of reads and wr_o during data cycles of writes, and the other strobe stays inactive. With 1, rd_o carries the direction (active means read) for the whole transfer and wr_o is an enable strobe during the data cycles.
- R8: A polarity bit of 1 makes the matching pin active low: cs_pol_i bit per chip select, strb_pol_i bit per region for rd_o and wr_o, and ale_pol_i for ale_o.
- R9: With mux_en_i set, the address phase drives the address on pd_o with pd_oe_o high and ale_o active. With it clear, ale_o never becomes active and the data pins are not driven in the address phase.
- R10: cs_mode_i 0 uses all 16 address pins and activates no chip select, using region 0 timing. Mode 1 activates cs_o[0] on every transfer, and addr_o[15] carries its level. Modes 2 and 3 pick region 1 (cs_o[1]) when address bit 14 is 1 and region 0 (cs_o[0]) otherwise; addr_o[15] carries the cs_o[0] level and addr_o[14] the cs_o[1] level. At most one chip select is active at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Transfer request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Base address of the word |
| wdata_i | input | 16 | Write word |
| width_i | input | 2 | Bus width code |
| cs_mode_i | input | 2 | Number of top address lines used as chip selects |
| mux_en_i | input | 1 | Address/data multiplexing enable |
| addr_wait_i | input | 4 | Extra address-phase cycles |
| data_wait_i | input | 8 | Extra data-phase cycles, region 1 in bits 7:4, region 0 in 3:0 |
| strb_style_i | input | 2 | Strobe style per region |
| cs_pol_i | input | 2 | Active-low select per chip select |
| strb_pol_i | input | 2 | Active-low select for strobes per region |
| ale_pol_i | input | 1 | Active-low select for the address-latch strobe |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read word |
| addr_o | output | 16 | Address pins, top lines may carry chip selects |
| pd_o | output | 16 | Data pin output value |
| pd_oe_o | output | 1 | Data pin output enable |
| pd_i | input | 16 | Data pin input value |
| cs_o | output | 2 | Chip select pins |
| rd_o | output | 1 | Read strobe or direction pin |
| wr_o | output | 1 | Write strobe or enable pin |
| ale_o | output | 1 | Address-latch strobe |

## Verification
Some rules can be judged from a single cycle, and the assertions check these on every cycle. A request seen while idle must raise busy, and done must last one cycle and never occur while idle. The data pins must float in the data and hold phases of a read. At most one chip select may be active, the latch strobe may appear only in a multiplexed address phase, and the pins must stay quiet while idle. Other behaviour can only be seen across a whole transfer, and the bench's scenarios show it. This covers the exact cycle counts of each phase per region, the order and addresses of narrow beats, and the assembly of the read and write words. It also covers the strobe style per region, inverted polarities, the ignoring of a request made mid-transfer, and reset arriving mid-transfer.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

  localparam int WORD_W = 16;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_DATA = 3'd2,
    PH_HOLD = 3'd3,
    PH_FIN  = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    BW_NIB  = 2'd0,
    BW_BYTE = 2'd1,
    BW_WORD = 2'd2,
    BW_WALT = 2'd3
  } bus_width_e;

  // index of the final beat for a width code
  function automatic logic [1:0] final_beat(input logic [1:0] w);
    case (w)
      2'd0:    return 2'd3;
      2'd1:    return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/pbm_region.sv
module pbm_region #(
  parameter int AW  = 16,
  parameter int NCS = 2
) (
  input  logic [1:0]    cs_mode_i,
  input  logic          sel_bit_i,
  input  logic [AW-1:0] beat_addr_i,
  output logic          sel_o,
  output logic [NCS-1:0] cs_act_o,
  output logic [AW-1:0] line_o
);

  always_comb begin
    line_o   = beat_addr_i;
    sel_o    = 1'b0;
    cs_act_o = '0;
    unique case (cs_mode_i)
      2'd0: begin
      end
      2'd1: begin
        cs_act_o[0]  = 1'b1;
        line_o[AW-1] = 1'b0;
      end
      default: begin
        sel_o        = sel_bit_i;
        cs_act_o[0]  = ~sel_bit_i;
        cs_act_o[1]  = sel_bit_i;
        line_o[AW-1] = 1'b0;
        line_o[AW-2] = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/pbm_ctrl.sv
module pbm_ctrl
  import pbm_pkg::*;
#(
  parameter int AW     = 16,
  parameter int WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [1:0]        width_i,
  input  logic [WAIT_W-1:0] addr_wait_i,
  input  logic [WAIT_W-1:0] data_wait_i,
  input  logic [WORD_W-1:0] pd_i,
  output phase_e            phase_o,
  output logic              rd_o,
  output logic              sel_bit_o,
  output logic [AW-1:0]     beat_addr_o,
  output logic [WORD_W-1:0] beat_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rdata_o
);

  localparam logic [WAIT_W-1:0] CNT_ONE = WAIT_W'(1);

  phase_e              phase_q, phase_d;
  logic [WAIT_W-1:0]   cnt_q, cnt_d;
  logic [1:0]          beat_q, beat_d;
  logic [1:0]          last_q;
  logic [1:0]          wsel_q;
  logic                rd_q;
  logic [AW-1:0]       base_q;
  logic [WORD_W-1:0]   wdat_q;
  logic [WORD_W-1:0]   rdat_q, rdat_d;
  logic                ld_en;
  logic                samp_en;
  logic [3:0]          shift;
  logic [WORD_W-1:0]   slice_mask;

  assign ld_en   = (phase_q == PH_IDLE) && req_i;
  assign samp_en = (phase_q == PH_DATA) && (cnt_q == '0) && rd_q;

  // next-state logic
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    beat_d  = beat_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_i) begin
          phase_d = PH_ADDR;
          cnt_d   = addr_wait_i;
          beat_d  = 2'd0;
        end
      end
      PH_ADDR: begin
        if (cnt_q == '0) begin
          phase_d = PH_DATA;
          cnt_d   = data_wait_i;
        end else begin
          cnt_d = cnt_q - CNT_ONE;
        end
      end
      PH_DATA: begin
        if (cnt_q == '0) phase_d = PH_HOLD;
        else             cnt_d   = cnt_q - CNT_ONE;
      end
      PH_HOLD: begin
        if (beat_q == last_q) begin
          phase_d = PH_FIN;
        end else begin
          phase_d = PH_ADDR;
          cnt_d   = addr_wait_i;
          beat_d  = beat_q + 2'd1;
        end
      end
      PH_FIN:  phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  // read assembly: place the sampled slice by beat position
  always_comb begin
    rdat_d = rdat_q;
    unique case (wsel_q)
      2'd0: begin
        unique case (beat_q)
          2'd0: rdat_d[3:0]   = pd_i[3:0];
          2'd1: rdat_d[7:4]   = pd_i[3:0];
          2'd2: rdat_d[11:8]  = pd_i[3:0];
          default: rdat_d[15:12] = pd_i[3:0];
        endcase
      end
      2'd1: begin
        if (beat_q[0]) rdat_d[15:8] = pd_i[7:0];
        else           rdat_d[7:0]  = pd_i[7:0];
      end
      default: rdat_d = pd_i;
    endcase
  end

  // write slice selection
  always_comb begin
    unique case (wsel_q)
      2'd0: begin
        shift      = {beat_q, 2'b00};
        slice_mask = WORD_W'({NIB_W{1'b1}});
      end
      2'd1: begin
        shift      = {beat_q[0], 3'b000};
        slice_mask = WORD_W'({BYTE_W{1'b1}});
      end
      default: begin
        shift      = 4'd0;
        slice_mask = {WORD_W{1'b1}};
      end
    endcase
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      beat_q  <= '0;
      last_q  <= '0;
      wsel_q  <= '0;
      rd_q    <= 1'b0;
      base_q  <= '0;
      wdat_q  <= '0;
      rdat_q  <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      beat_q  <= beat_d;
      if (ld_en) begin
        base_q <= addr_i;
        wdat_q <= wdata_i;
        rd_q   <= ~we_i;
        wsel_q <= width_i;
        last_q <= final_beat(width_i);
      end
      if (samp_en) rdat_q <= rdat_d;
    end
  end

  assign phase_o     = phase_q;
  assign rd_o        = rd_q;
  assign sel_bit_o   = base_q[AW-2];
  assign beat_addr_o = base_q + AW'(beat_q);
  assign beat_data_o = (wdat_q >> shift) & slice_mask;
  assign busy_o      = (phase_q != PH_IDLE);
  assign done_o      = (phase_q == PH_FIN);
  assign rdata_o     = rdat_q;

endmodule

// File: rtl/pbm_pads.sv
module pbm_pads
  import pbm_pkg::*;
#(
  parameter int AW  = 16,
  parameter int NCS = 2
) (
  input  phase_e            phase_i,
  input  logic              rd_i,
  input  logic              mux_i,
  input  logic              style_i,
  input  logic              strb_pol_i,
  input  logic [NCS-1:0]    cs_pol_i,
  input  logic              ale_pol_i,
  input  logic [NCS-1:0]    cs_act_i,
  input  logic [1:0]        cs_mode_i,
  input  logic [AW-1:0]     line_i,
  input  logic [WORD_W-1:0] beat_data_i,
  output logic [AW-1:0]     addr_o,
  output logic [WORD_W-1:0] pd_o,
  output logic              pd_oe_o,
  output logic [NCS-1:0]    cs_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              ale_o
);

  logic           in_xfer, in_addr, in_data, in_hold, addr_drv;
  logic [NCS-1:0] cs_on;
  logic           rd_act, wr_act;

  assign in_addr  = (phase_i == PH_ADDR);
  assign in_data  = (phase_i == PH_DATA);
  assign in_hold  = (phase_i == PH_HOLD);
  assign in_xfer  = in_addr | in_data | in_hold;
  assign addr_drv = in_addr & mux_i;
  assign cs_on    = in_xfer ? cs_act_i : '0;

  for (genvar g = 0; g < NCS; g++) begin : g_cs_pin
    assign cs_o[g] = cs_on[g] ^ cs_pol_i[g];
  end

  always_comb begin
    addr_o = line_i;
    if (cs_mode_i != 2'd0) addr_o[AW-1] = cs_o[0];
    if (cs_mode_i[1])      addr_o[AW-2] = cs_o[1];
  end

  always_comb begin
    if (style_i) begin
      rd_act = in_xfer & rd_i;
      wr_act = in_data;
    end else begin
      rd_act = in_data & rd_i;
      wr_act = in_data & ~rd_i;
    end
  end

  assign rd_o    = rd_act ^ strb_pol_i;
  assign wr_o    = wr_act ^ strb_pol_i;
  assign ale_o   = addr_drv ^ ale_pol_i;
  assign pd_oe_o = addr_drv | ((in_data | in_hold) & ~rd_i);
  assign pd_o    = addr_drv ? WORD_W'(addr_o) : beat_data_i;

endmodule

// File: rtl/extbus_master.sv
module extbus_master
  import pbm_pkg::*;
#(
  parameter int AW     = 16,
  parameter int WAIT_W = 4,
  parameter int NCS    = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [WORD_W-1:0]   wdata_i,
  input  logic [1:0]          width_i,
  input  logic [1:0]          cs_mode_i,
  input  logic                mux_en_i,
  input  logic [WAIT_W-1:0]   addr_wait_i,
  input  logic [NCS*WAIT_W-1:0] data_wait_i,
  input  logic [NCS-1:0]      strb_style_i,
  input  logic [NCS-1:0]      cs_pol_i,
  input  logic [NCS-1:0]      strb_pol_i,
  input  logic                ale_pol_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [WORD_W-1:0]   rdata_o,
  output logic [AW-1:0]       addr_o,
  output logic [WORD_W-1:0]   pd_o,
  output logic                pd_oe_o,
  input  logic [WORD_W-1:0]   pd_i,
  output logic [NCS-1:0]      cs_o,
  output logic                rd_o,
  output logic                wr_o,
  output logic                ale_o
);

  logic [1:0]        rst_pipe_q;
  logic              rst_n_int;
  phase_e            ph;
  logic              rd_dir;
  logic              sel_bit;
  logic              sel;
  logic [AW-1:0]     beat_addr;
  logic [AW-1:0]     line_addr;
  logic [WORD_W-1:0] beat_data;
  logic [NCS-1:0]    cs_act;
  logic [WAIT_W-1:0] dwait_sel;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  assign dwait_sel = data_wait_i[sel*WAIT_W +: WAIT_W];

  pbm_ctrl #(.AW(AW), .WAIT_W(WAIT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_int),
    .req_i       (req_i),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .width_i     (width_i),
    .addr_wait_i (addr_wait_i),
    .data_wait_i (dwait_sel),
    .pd_i        (pd_i),
    .phase_o     (ph),
    .rd_o        (rd_dir),
    .sel_bit_o   (sel_bit),
    .beat_addr_o (beat_addr),
    .beat_data_o (beat_data),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .rdata_o     (rdata_o)
  );

  pbm_region #(.AW(AW), .NCS(NCS)) u_region (
    .cs_mode_i   (cs_mode_i),
    .sel_bit_i   (sel_bit),
    .beat_addr_i (beat_addr),
    .sel_o       (sel),
    .cs_act_o    (cs_act),
    .line_o      (line_addr)
  );

  pbm_pads #(.AW(AW), .NCS(NCS)) u_pads (
    .phase_i     (ph),
    .rd_i        (rd_dir),
    .mux_i       (mux_en_i),
    .style_i     (strb_style_i[sel]),
    .strb_pol_i  (strb_pol_i[sel]),
    .cs_pol_i    (cs_pol_i),
    .ale_pol_i   (ale_pol_i),
    .cs_act_i    (cs_act),
    .cs_mode_i   (cs_mode_i),
    .line_i      (line_addr),
    .beat_data_i (beat_data),
    .addr_o      (addr_o),
    .pd_o        (pd_o),
    .pd_oe_o     (pd_oe_o),
    .cs_o        (cs_o),
    .rd_o        (rd_o),
    .wr_o        (wr_o),
    .ale_o       (ale_o)
  );

endmodule

// File: rtl/extbus_master_chk.sv
module extbus_master_chk
  import pbm_pkg::*;
#(
  parameter int NCS = 2
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           req_i,
  input logic           busy_o,
  input logic           done_o,
  input logic           pd_oe_o,
  input logic [NCS-1:0] cs_o,
  input logic [NCS-1:0] cs_pol_i,
  input logic           ale_o,
  input logic           ale_pol_i,
  input logic           mux_en_i,
  input phase_e         phase_i,
  input logic           rd_dir_i
);

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!pd_oe_o && (cs_o == cs_pol_i)));

  p_req_taken_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i) |=> busy_o);

  p_done_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  p_read_float_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_dir_i && (phase_i == PH_DATA || phase_i == PH_HOLD)) |-> !pd_oe_o);

  p_ale_addr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ale_o != ale_pol_i) |-> (phase_i == PH_ADDR && mux_en_i));

  p_cs_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_o ^ cs_pol_i));

endmodule

bind extbus_master extbus_master_chk #(.NCS(NCS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_n_int),
  .req_i     (req_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .pd_oe_o   (pd_oe_o),
  .cs_o      (cs_o),
  .cs_pol_i  (cs_pol_i),
  .ale_o     (ale_o),
  .ale_pol_i (ale_pol_i),
  .mux_en_i  (mux_en_i),
  .phase_i   (ph),
  .rd_dir_i  (rd_dir)
);

// File: tb/extbus_master_bench.sv
module extbus_master_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        req_i, we_i, mux_en_i, ale_pol_i;
  logic [15:0] addr_i, wdata_i;
  logic [1:0]  width_i, cs_mode_i, strb_style_i, cs_pol_i, strb_pol_i;
  logic [3:0]  addr_wait_i;
  logic [7:0]  data_wait_i;
  logic        busy_o, done_o, pd_oe_o, rd_o, wr_o, ale_o;
  logic [15:0] rdata_o, addr_o, pd_o, pd_i;
  logic [1:0]  cs_o;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  function automatic logic [15:0] memf(input logic [7:0] a);
    return {a ^ 8'h5A, ~a};
  endfunction

  assign pd_i = memf(addr_o[7:0]);

  extbus_master u_extbus_master (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .width_i(width_i),
    .cs_mode_i(cs_mode_i), .mux_en_i(mux_en_i), .addr_wait_i(addr_wait_i),
    .data_wait_i(data_wait_i), .strb_style_i(strb_style_i),
    .cs_pol_i(cs_pol_i), .strb_pol_i(strb_pol_i), .ale_pol_i(ale_pol_i),
    .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o), .addr_o(addr_o),
    .pd_o(pd_o), .pd_oe_o(pd_oe_o), .pd_i(pd_i), .cs_o(cs_o),
    .rd_o(rd_o), .wr_o(wr_o), .ale_o(ale_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {width[41:40], csmode[39:38], mux[37], read[36], addr[35:20], wdata[19:4], awaits[3:0]}
  localparam int NV = 7;
  localparam logic [41:0] VEC [NV] = '{
    {2'd2, 2'd0, 1'b0, 1'b0, 16'h1234, 16'hC3A1, 4'd0},
    {2'd1, 2'd0, 1'b1, 1'b1, 16'h00F0, 16'h0000, 4'd1},
    {2'd0, 2'd1, 1'b0, 1'b0, 16'h8001, 16'hBEEF, 4'd2},
    {2'd0, 2'd2, 1'b1, 1'b1, 16'h4002, 16'h0000, 4'd0},
    {2'd2, 2'd2, 1'b0, 1'b1, 16'h0010, 16'h0000, 4'd3},
    {2'd1, 2'd2, 1'b1, 1'b0, 16'h40FF, 16'h5AA5, 4'd1},
    {2'd2, 2'd1, 1'b1, 1'b1, 16'h7FFF, 16'h0000, 4'd0}
  };

  task automatic run_xfer(input logic [1:0] wd, input logic [1:0] csm, input logic mx,
                          input logic rdn, input logic [15:0] a, input logic [15:0] wv,
                          input logic [3:0] aw);
    int w, nb, set, dw, cyc, strb, alec, beat;
    bit sty, pol, ds, prev_ds, style_err, ale_err, oe_err, addr_err, pin_err;
    logic [15:0] mask, wword, expw, exp_rd;
    logic [1:0]  cs_seen, cs_exp;
    w    = (wd == 2'd0) ? 4 : (wd == 2'd1) ? 8 : 16;
    nb   = 16 / w;
    mask = (w == 16) ? 16'hFFFF : ((16'h1 << w) - 16'h1);
    set  = (csm[1] && a[14]) ? 1 : 0;
    dw   = set ? int'(data_wait_i[7:4]) : int'(data_wait_i[3:0]);
    sty  = strb_style_i[set];
    pol  = strb_pol_i[set];
    cs_exp = (csm == 2'd0) ? 2'b00 : (csm == 2'd1) ? 2'b01 : (set ? 2'b10 : 2'b01);
    exp_rd = '0;
    for (int k = 0; k < nb; k++)
      exp_rd = exp_rd | ((memf(8'(a + 16'(k))) & mask) << (k * w));
    width_i = wd; cs_mode_i = csm; mux_en_i = mx; addr_wait_i = aw;
    addr_i = a; wdata_i = wv; we_i = ~rdn; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    chk(busy_o == 1'b1, "R2 busy after accept", busy_o, 1);
    cyc = 0; strb = 0; alec = 0; beat = 0; prev_ds = 0;
    style_err = 0; ale_err = 0; oe_err = 0; addr_err = 0; pin_err = 0;
    wword = '0; cs_seen = '0;
    while (!done_o && cyc < 2000) begin
      if (sty) begin
        ds = wr_o ^ pol;
        if ((rd_o ^ pol) != rdn) style_err = 1;
      end else begin
        ds = rdn ? (rd_o ^ pol) : (wr_o ^ pol);
        if ((rdn ? wr_o : rd_o) != pol) style_err = 1;
      end
      if (ale_o != ale_pol_i) begin
        alec++;
        if (pd_o != addr_o || !pd_oe_o) ale_err = 1;
      end
      if (ds) begin
        strb++;
        if (rdn && pd_oe_o) oe_err = 1;
        if (!rdn && !pd_oe_o) oe_err = 1;
        if (!prev_ds && beat < 4) begin
          if (addr_o[7:0] != 8'(a + 16'(beat))) addr_err = 1;
          cs_seen = cs_o ^ cs_pol_i;
          if (csm == 2'd1 && addr_o[15] != cs_o[0]) pin_err = 1;
          if (csm[1] && addr_o[15:14] != {cs_o[0], cs_o[1]}) pin_err = 1;
          if (!rdn) wword = wword | ((pd_o & mask) << (beat * w));
        end
      end
      if (!ds && prev_ds) beat++;
      prev_ds = ds;
      cyc++;
      @(negedge clk_i);
    end
    chk(cyc == nb * (3 + int'(aw) + dw), "R3 transfer cycles", cyc, nb * (3 + int'(aw) + dw));
    chk(beat == nb && !addr_err, "R4 beat count/addresses", beat, nb);
    chk(strb == nb * (1 + dw) && !style_err, "R7 strobe cycles/style", strb, nb * (1 + dw));
    chk(!oe_err, rdn ? "R5 bus floats on read" : "R6 bus driven on write", oe_err, 0);
    chk(alec == (mx ? nb * (1 + int'(aw)) : 0) && !ale_err, "R9 latch strobe", alec,
        mx ? nb * (1 + int'(aw)) : 0);
    chk(cs_seen == cs_exp && !pin_err, "R10 chip select", cs_seen, cs_exp);
    expw = rdn ? exp_rd : wv;
    if (rdn) chk(rdata_o == expw, "R5 read word", rdata_o, expw);
    else     chk(wword == expw, "R6 write word", wword, expw);
    chk(busy_o == 1'b1, "R3 busy with done", busy_o, 1);
    @(negedge clk_i);
    chk(done_o == 1'b0 && busy_o == 1'b0, "R3 done one cycle", {done_o, busy_o}, 0);
  endtask

  task automatic check_idle(input string req);
    chk(busy_o == 0 && done_o == 0 && pd_oe_o == 0, {req, " idle flags"},
        {busy_o, done_o, pd_oe_o}, 0);
    chk(cs_o == cs_pol_i && rd_o == strb_pol_i[0] && wr_o == strb_pol_i[0] && ale_o == ale_pol_i,
        {req, " idle pin levels"}, {cs_o, rd_o, wr_o, ale_o},
        {cs_pol_i, strb_pol_i[0], strb_pol_i[0], ale_pol_i});
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int dones;
    rst_ni = 1'b0; req_i = 0; we_i = 0; addr_i = 0; wdata_i = 0;
    width_i = 2'd2; cs_mode_i = 0; mux_en_i = 0; addr_wait_i = 0;
    data_wait_i = {4'd5, 4'd2}; strb_style_i = 2'b10;
    cs_pol_i = 2'b00; strb_pol_i = 2'b00; ale_pol_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check_idle("R1 reset");

    foreach (VEC[i])
      run_xfer(VEC[i][41:40], VEC[i][39:38], VEC[i][37], VEC[i][36],
               VEC[i][35:20], VEC[i][19:4], VEC[i][3:0]);

    // R2: request during a transfer is ignored
    width_i = 2'd2; cs_mode_i = 0; mux_en_i = 0; addr_wait_i = 0;
    addr_i = 16'h0020; we_i = 0; req_i = 1;
    @(negedge clk_i);
    req_i = 0;
    @(negedge clk_i);
    addr_i = 16'h0077; req_i = 1;
    dones = 0;
    for (int c = 0; c < 30; c++) begin
      if (c == 2) req_i = 0;
      if (done_o) begin
        dones++;
        chk(rdata_o == memf(8'h20), "R2 busy request ignored data", rdata_o, memf(8'h20));
      end
      @(negedge clk_i);
    end
    chk(dones == 1, "R2 single completion", dones, 1);
    chk(busy_o == 0, "R2 idle after ignored request", busy_o, 0);

    // R8: inverted polarities
    cs_pol_i = 2'b10; strb_pol_i = 2'b11; ale_pol_i = 1'b1;
    @(negedge clk_i);
    check_idle("R8 polarity");
    run_xfer(2'd1, 2'd2, 1'b1, 1'b1, 16'h4031, 16'h0000, 4'd1);
    run_xfer(2'd0, 2'd2, 1'b1, 1'b0, 16'h0005, 16'h9C3E, 4'd0);

    // R1: reset in the middle of a transfer
    width_i = 2'd0; addr_wait_i = 4'd3; addr_i = 16'h0100; we_i = 1; req_i = 1;
    @(negedge clk_i);
    req_i = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check_idle("R1 mid-transfer reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check_idle("R1 after release");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule